// File: doc/BRIEF.md
# Unified Reservation Station

This block is the shared waiting pool between rename and the execution units of an out-of-order core. Each renamed micro-op arrives with a class (integer, floating-point or memory), an opcode, a destination tag and two source operands. Each source comes either as a value or as the tag of the micro-op that will produce it. Entries whose sources are still pending snoop a set of result buses. When a bus carries a matching tag, the entry copies that value and marks the source as present.

Each cycle the station looks at every entry with both sources present and hands it to a dispatch port of the matching class. The integer, floating-point and memory ports are each arbitrated on their own. Among candidates of one class, the entry that has waited longest goes first. A global cap limits how many micro-ops leave per cycle, and a flush empties the pool. Insertion stalls while no slot is free.

Top module: `unified_rs`

## Requirements
- R1: `in_ready` is low while every slot holds a micro-op, and an insert offered while `in_ready` is low is dropped. With at least one free slot and no flush, `in_ready` is high.
- R2: A source that is marked present at insertion reaches the dispatch port with its value unchanged, and so do the opcode and the destination tag.
- R3: A pending source takes the data of a result bus whose valid is high and whose tag equals the source tag. The captured value is the one that appears at dispatch.
- R4: A pending source whose tag matches a result bus in the same cycle it is inserted is captured at insertion, so no later broadcast is needed.
- R5: Class encoding is 0 integer, 1 floating-point, 2 memory. Each port has a fixed class (default: ports 0 and 1 integer, port 2 floating-point, ports 3 and 4 memory), and a micro-op leaves only through a port of its own class.
- R6: Among ready entries of one class, the one inserted earliest goes to the lowest-numbered eligible port of that class, the next oldest to the next such port.
- R7: A port raises `du_valid` only while its `du_ready` is high. A port that is not ready leaves its candidate to the next port of the same class.
- R8: At most `DISP_LIMIT` (default 4) micro-ops leave per cycle. When more are eligible, lower-numbered ports are served first.
- R9: A micro-op shown with `du_valid` high leaves the station at that clock edge, so each accepted micro-op is dispatched exactly once.
- R10: While `flush` is high, no port dispatches and `in_ready` is low. After the flush edge the station is empty.
- R11: After reset the station is empty, `in_ready` is high and all `du_valid` bits are low.
- R12: An entry with a pending source is not dispatched. A source captured from a broadcast allows dispatch from the following cycle on, not in the broadcast cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries |
| in_valid | input | 1 | Insert request |
| in_ready | output | 1 | A free slot exists and no flush |
| in_cls | input | 2 | Class: 0 int, 1 fp, 2 mem |
| in_op | input | 8 | Opcode payload |
| in_dst | input | 4 | Destination tag |
| in_a_rdy | input | 1 | Source A value is present |
| in_a_tag | input | 4 | Source A producer tag |
| in_a_val | input | 16 | Source A value |
| in_b_rdy | input | 1 | Source B value is present |
| in_b_tag | input | 4 | Source B producer tag |
| in_b_val | input | 16 | Source B value |
| bc_valid | input | NUM_BC | Result bus valids |
| bc_tag | input | NUM_BC x 4 | Result bus tags |
| bc_data | input | NUM_BC x 16 | Result bus values |
| du_ready | input | NUM_PORTS | Unit can accept on this port |
| du_valid | output | NUM_PORTS | Micro-op presented and taken |
| du_op | output | NUM_PORTS x 8 | Dispatched opcode |
| du_dst | output | NUM_PORTS x 4 | Dispatched destination tag |
| du_a | output | NUM_PORTS x 16 | Dispatched source A value |
| du_b | output | NUM_PORTS x 16 | Dispatched source B value |

## Verification
The hardest case to reach from the ports is the cap in R8. It only binds when every port has a ready candidate of its own class in the same cycle. The stimulus gets there by holding all units not ready while it fills the pool with a chosen mix of two integer, one floating-point, two memory and three further integer micro-ops. It then releases every port at once, so the first cycle shows the cap, and the following cycles show the oldest-first order among the leftovers. A second awkward case is a broadcast that arrives in the very cycle of insertion. A table row and a directed step line the two up so that the source is satisfied without any later broadcast.

// File: rtl/urs_pkg.sv
package urs_pkg;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 4;
  localparam int OP_W   = 8;
  localparam int CLS_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_MEM = 2'd2
  } ucls_e;

  typedef struct packed {
    logic              rdy;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] val;
  } opnd_t;

  typedef struct packed {
    ucls_e            cls;
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] dst;
    opnd_t            a;
    opnd_t            b;
  } uop_t;
endpackage

// File: rtl/urs_capture.sv
module urs_capture
  import urs_pkg::*;
#(
  parameter int NUM_BC = 2
) (
  input  opnd_t                          cur,
  input  logic [NUM_BC-1:0]              bc_valid,
  input  logic [NUM_BC-1:0][TAG_W-1:0]   bc_tag,
  input  logic [NUM_BC-1:0][DATA_W-1:0]  bc_data,
  output opnd_t                          nxt
);
  // Lowest-numbered matching bus wins if two carry the same tag.
  always_comb begin
    nxt = cur;
    for (int b = NUM_BC - 1; b >= 0; b--) begin
      if (!cur.rdy && bc_valid[b] && (bc_tag[b] == cur.tag)) begin
        nxt.rdy = 1'b1;
        nxt.val = bc_data[b];
      end
    end
  end
endmodule

// File: rtl/urs_entry.sv
module urs_entry
  import urs_pkg::*;
#(
  parameter int NUM_BC = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          alloc,
  input  uop_t                          ins,
  input  logic [NUM_BC-1:0]             bc_valid,
  input  logic [NUM_BC-1:0][TAG_W-1:0]  bc_tag,
  input  logic [NUM_BC-1:0][DATA_W-1:0] bc_data,
  input  logic                          free,
  output logic                          valid,
  output uop_t                          cur,
  output logic                          ready
);
  opnd_t a_nxt, b_nxt;

  urs_capture #(.NUM_BC(NUM_BC)) cap_a_i (
    .cur(cur.a), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .nxt(a_nxt)
  );
  urs_capture #(.NUM_BC(NUM_BC)) cap_b_i (
    .cur(cur.b), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .nxt(b_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cur   <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (alloc) begin
      valid <= 1'b1;
      cur   <= ins;
    end else begin
      if (free) valid <= 1'b0;
      cur.a <= a_nxt;
      cur.b <= b_nxt;
    end
  end

  assign ready = valid && cur.a.rdy && cur.b.rdy;

  // A slot is only written when it is empty.
  p_alloc_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !valid);

  // A snooped match on a held entry marks the source present next cycle.
  p_capture_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !flush && !free && !cur.a.rdy && a_nxt.rdy) |=> cur.a.rdy);
  p_capture_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !flush && !free && !cur.b.rdy && b_nxt.rdy) |=> cur.b.rdy);

  // Only an entry with both sources present may be released.
  p_free_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    free |-> (cur.a.rdy && cur.b.rdy && valid));
endmodule

// File: rtl/urs_age.sv
module urs_age #(
  parameter int ENTRIES = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ENTRIES-1:0]                alloc,
  input  logic [ENTRIES-1:0]                live,
  input  logic [ENTRIES-1:0]                valid,
  output logic [ENTRIES-1:0][ENTRIES-1:0]   elder
);
  // elder[i][j] = 1 means entry j was inserted before entry i.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elder <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc[i]) elder[i] <= live & ~alloc;
        else          elder[i] <= elder[i] & ~alloc;
      end
    end
  end

  // Any two live entries are strictly ordered.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    for (genvar j = i + 1; j < ENTRIES; j++) begin : g_col
      p_age_total_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid[i] && valid[j]) |-> (elder[i][j] != elder[j][i]));
    end
  end
endmodule

// File: rtl/urs_select.sv
module urs_select #(
  parameter int ENTRIES    = 8,
  parameter int NUM_PORTS  = 5,
  parameter int DISP_LIMIT = 4,
  parameter logic [2*NUM_PORTS-1:0] PORT_CLS = 10'b10_10_01_00_00
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              enable,
  input  logic [ENTRIES-1:0]                ready_m,
  input  logic [ENTRIES-1:0][1:0]           cls_v,
  input  logic [ENTRIES-1:0][ENTRIES-1:0]   elder,
  input  logic [NUM_PORTS-1:0]              du_ready,
  output logic [NUM_PORTS-1:0][ENTRIES-1:0] grant,
  output logic [NUM_PORTS-1:0]              gvalid
);
  function automatic logic [ENTRIES-1:0] oldest_of(
    input logic [ENTRIES-1:0]              cand,
    input logic [ENTRIES-1:0][ENTRIES-1:0] eld
  );
    logic [ENTRIES-1:0] r;
    for (int i = 0; i < ENTRIES; i++) r[i] = cand[i] && !(|(cand & eld[i]));
    return r;
  endfunction

  function automatic logic [ENTRIES-1:0] class_mask(
    input logic [ENTRIES-1:0][1:0] cv,
    input logic [1:0]              want
  );
    logic [ENTRIES-1:0] m;
    for (int i = 0; i < ENTRIES; i++) m[i] = (cv[i] == want);
    return m;
  endfunction

  logic [ENTRIES-1:0] taken;
  logic [ENTRIES-1:0] cand;
  int                 used;

  // Ports are served in index order; each takes the oldest untaken candidate.
  always_comb begin
    taken = '0;
    used  = 0;
    cand  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      grant[p] = '0;
      if (enable && du_ready[p] && (used < DISP_LIMIT)) begin
        cand     = ready_m & ~taken & class_mask(cls_v, PORT_CLS[2*p +: 2]);
        grant[p] = oldest_of(cand, elder);
        if (|grant[p]) used = used + 1;
        taken    = taken | grant[p];
      end
      gvalid[p] = |grant[p];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant[p]));
    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_other
      p_grant_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[p] & grant[q]) == '0);
    end
  end
endmodule

// File: rtl/unified_rs.sv
module unified_rs
  import urs_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int NUM_BC     = 2,
  parameter int NUM_PORTS  = 5,
  parameter int DISP_LIMIT = 4,
  parameter logic [2*NUM_PORTS-1:0] PORT_CLS = 10'b10_10_01_00_00
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [CLS_W-1:0]                  in_cls,
  input  logic [OP_W-1:0]                   in_op,
  input  logic [TAG_W-1:0]                  in_dst,
  input  logic                              in_a_rdy,
  input  logic [TAG_W-1:0]                  in_a_tag,
  input  logic [DATA_W-1:0]                 in_a_val,
  input  logic                              in_b_rdy,
  input  logic [TAG_W-1:0]                  in_b_tag,
  input  logic [DATA_W-1:0]                 in_b_val,
  input  logic [NUM_BC-1:0]                 bc_valid,
  input  logic [NUM_BC-1:0][TAG_W-1:0]      bc_tag,
  input  logic [NUM_BC-1:0][DATA_W-1:0]     bc_data,
  input  logic [NUM_PORTS-1:0]              du_ready,
  output logic [NUM_PORTS-1:0]              du_valid,
  output logic [NUM_PORTS-1:0][OP_W-1:0]    du_op,
  output logic [NUM_PORTS-1:0][TAG_W-1:0]   du_dst,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  du_a,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  du_b
);
  logic [ENTRIES-1:0]              valid, ready_m, free, alloc, live;
  logic [ENTRIES-1:0][1:0]         cls_v;
  logic [ENTRIES-1:0][ENTRIES-1:0] elder;
  logic [NUM_PORTS-1:0][ENTRIES-1:0] grant;
  uop_t                            ent [ENTRIES];
  uop_t                            ins_raw, ins_cap;
  opnd_t                           a_byp, b_byp;
  logic                            in_fire, slot_found;

  // Insert side: stall when full or flushing; lowest free slot is used.
  assign in_ready = !flush && !(&valid);
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    alloc      = '0;
    slot_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !slot_found) begin
        alloc[i]   = in_fire;
        slot_found = 1'b1;
      end
    end
  end

  always_comb begin
    ins_raw       = '0;
    ins_raw.cls   = ucls_e'(in_cls);
    ins_raw.op    = in_op;
    ins_raw.dst   = in_dst;
    ins_raw.a     = '{rdy: in_a_rdy, tag: in_a_tag, val: in_a_val};
    ins_raw.b     = '{rdy: in_b_rdy, tag: in_b_tag, val: in_b_val};
    ins_cap       = ins_raw;
    ins_cap.a     = a_byp;
    ins_cap.b     = b_byp;
  end

  // Same-cycle capture for sources that match a bus while being inserted.
  urs_capture #(.NUM_BC(NUM_BC)) ins_a_i (
    .cur(ins_raw.a), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .nxt(a_byp)
  );
  urs_capture #(.NUM_BC(NUM_BC)) ins_b_i (
    .cur(ins_raw.b), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .nxt(b_byp)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    urs_entry #(.NUM_BC(NUM_BC)) ent_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .alloc(alloc[g]), .ins(ins_cap),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .free(free[g]), .valid(valid[g]), .cur(ent[g]), .ready(ready_m[g])
    );
    assign cls_v[g] = ent[g].cls;
  end

  assign live = valid & ~free;

  urs_age #(.ENTRIES(ENTRIES)) age_i (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .live(live), .valid(valid), .elder(elder)
  );

  urs_select #(
    .ENTRIES(ENTRIES), .NUM_PORTS(NUM_PORTS), .DISP_LIMIT(DISP_LIMIT), .PORT_CLS(PORT_CLS)
  ) sel_i (
    .clk(clk), .rst_n(rst_n), .enable(!flush), .ready_m(ready_m), .cls_v(cls_v),
    .elder(elder), .du_ready(du_ready), .grant(grant), .gvalid(du_valid)
  );

  // Output muxes and release of granted entries.
  always_comb begin
    free = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      du_op[p]  = '0;
      du_dst[p] = '0;
      du_a[p]   = '0;
      du_b[p]   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (grant[p][i]) begin
          du_op[p]  = ent[i].op;
          du_dst[p] = ent[i].dst;
          du_a[p]   = ent[i].a.val;
          du_b[p]   = ent[i].b.val;
        end
      end
      free = free | grant[p];
    end
  end

  p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid) |-> !in_ready);
  p_port_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (du_valid & ~du_ready) == '0);
  p_dispatch_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(du_valid) <= DISP_LIMIT);
  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (du_valid == '0 && !in_ready));
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));
endmodule

// File: tb/unified_rs_tb_top.sv
module unified_rs_tb_top;
  localparam int NP = 5;
  localparam int NR = 10;

  typedef struct packed {
    logic        ins;
    logic [1:0]  cls;
    logic [7:0]  op;
    logic        ra;
    logic [3:0]  ta;
    logic        rb;
    logic [3:0]  tb;
    logic        bcv;
    logic [3:0]  bct;
    logic [4:0]  rdy;
    logic [4:0]  expv;
    logic [39:0] expop;
  } row_t;

  // Walk: int/fp/mem routing, waiting source, same-cycle capture, port skip.
  localparam row_t TBL [NR] = '{
    '{1'b1, 2'd0, 8'h01, 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0, 5'b00000, 5'b00000, 40'h0},
    '{1'b1, 2'd0, 8'h02, 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0, 5'b00000, 5'b00000, 40'h0},
    '{1'b1, 2'd1, 8'h03, 1'b1, 4'd0, 1'b0, 4'd5, 1'b0, 4'd0, 5'b00000, 5'b00000, 40'h0},
    '{1'b0, 2'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 5'b11111, 5'b00011, 40'h00_00_00_02_01},
    '{1'b1, 2'd2, 8'h04, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 4'd5, 5'b11111, 5'b00000, 40'h0},
    '{1'b0, 2'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 5'b11111, 5'b01100, 40'h00_04_03_00_00},
    '{1'b1, 2'd0, 8'h05, 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0, 5'b00000, 5'b00000, 40'h0},
    '{1'b1, 2'd0, 8'h06, 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0, 5'b11110, 5'b00010, 40'h00_00_00_05_00},
    '{1'b1, 2'd0, 8'h07, 1'b0, 4'd9, 1'b1, 4'd0, 1'b1, 4'd9, 5'b00000, 5'b00000, 40'h0},
    '{1'b0, 2'd0, 8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 5'b11111, 5'b00011, 40'h00_00_00_07_06}
  };

  logic clk = 1'b0;
  logic rst_n, flush, in_valid, in_ready;
  logic [1:0]  in_cls;
  logic [7:0]  in_op;
  logic [3:0]  in_dst, in_a_tag, in_b_tag;
  logic        in_a_rdy, in_b_rdy;
  logic [15:0] in_a_val, in_b_val;
  logic [1:0]  bc_valid;
  logic [1:0][3:0]  bc_tag;
  logic [1:0][15:0] bc_data;
  logic [NP-1:0] du_ready, du_valid;
  logic [NP-1:0][7:0]  du_op;
  logic [NP-1:0][3:0]  du_dst;
  logic [NP-1:0][15:0] du_a, du_b;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  unified_rs dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls), .in_op(in_op), .in_dst(in_dst),
    .in_a_rdy(in_a_rdy), .in_a_tag(in_a_tag), .in_a_val(in_a_val),
    .in_b_rdy(in_b_rdy), .in_b_tag(in_b_tag), .in_b_val(in_b_val),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .du_ready(du_ready), .du_valid(du_valid), .du_op(du_op), .du_dst(du_dst),
    .du_a(du_a), .du_b(du_b)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; in_cls = 2'd0; in_op = '0; in_dst = '0;
    in_a_rdy = 1'b0; in_a_tag = '0; in_a_val = '0;
    in_b_rdy = 1'b0; in_b_tag = '0; in_b_val = '0;
    bc_valid = '0; bc_tag = '0; bc_data = '0; du_ready = '0; flush = 1'b0;
  endtask

  task automatic put(input logic [1:0] c, input logic [7:0] op,
                     input logic ra, input logic [3:0] ta, input logic [15:0] va,
                     input logic rb, input logic [3:0] tb, input logic [15:0] vb);
    in_valid = 1'b1; in_cls = c; in_op = op; in_dst = op[3:0];
    in_a_rdy = ra; in_a_tag = ta; in_a_val = va;
    in_b_rdy = rb; in_b_tag = tb; in_b_val = vb;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R11: empty after reset
    chk(in_ready === 1'b1, "R11 in_ready", 64'(in_ready), 64'd1);
    chk(du_valid === '0, "R11 du_valid", 64'(du_valid), 64'd0);

    // Table walk (R5, R6, R7, R4, R12)
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      idle_inputs();
      if (TBL[r].ins)
        put(TBL[r].cls, TBL[r].op, TBL[r].ra, TBL[r].ta, {8'hA0, TBL[r].op},
            TBL[r].rb, TBL[r].tb, {8'hB0, TBL[r].op});
      bc_valid[0] = TBL[r].bcv;
      bc_tag[0]   = TBL[r].bct;
      bc_data[0]  = {12'hC00, TBL[r].bct};
      du_ready    = TBL[r].rdy;
      #2;
      chk(du_valid === TBL[r].expv, $sformatf("R5/R6/R7 row %0d mask", r),
          64'(du_valid), 64'(TBL[r].expv));
      for (int p = 0; p < NP; p++) begin
        if (TBL[r].expv[p])
          chk(du_op[p] === TBL[r].expop[8*p +: 8], $sformatf("R6 row %0d port %0d op", r, p),
              64'(du_op[p]), 64'(TBL[r].expop[8*p +: 8]));
      end
    end

    // R2, R3, R12: value paths and no dispatch in the broadcast cycle
    @(negedge clk); idle_inputs();
    put(2'd0, 8'h1A, 1'b1, 4'd0, 16'h1234, 1'b0, 4'd3, 16'h0);
    @(negedge clk); idle_inputs();
    bc_valid[1] = 1'b1; bc_tag[1] = 4'd3; bc_data[1] = 16'hBEEF; du_ready = 5'b00001;
    #2;
    chk(du_valid[0] === 1'b0, "R12 no dispatch in capture cycle", 64'(du_valid[0]), 64'd0);
    @(negedge clk); idle_inputs(); du_ready = 5'b00001;
    #2;
    chk(du_valid[0] === 1'b1, "R3 dispatch after capture", 64'(du_valid[0]), 64'd1);
    chk(du_a[0] === 16'h1234, "R2 source A value", 64'(du_a[0]), 64'h1234);
    chk(du_b[0] === 16'hBEEF, "R3 captured value", 64'(du_b[0]), 64'hBEEF);
    chk(du_dst[0] === 4'hA, "R2 destination tag", 64'(du_dst[0]), 64'hA);

    // R4: capture at insertion
    @(negedge clk); idle_inputs();
    put(2'd0, 8'h1B, 1'b0, 4'd7, 16'h0, 1'b1, 4'd0, 16'h0055);
    bc_valid[0] = 1'b1; bc_tag[0] = 4'd7; bc_data[0] = 16'h7777;
    @(negedge clk); idle_inputs(); du_ready = 5'b00001;
    #2;
    chk(du_valid[0] === 1'b1 && du_a[0] === 16'h7777, "R4 insert-cycle capture",
        64'({du_valid[0], du_a[0]}), 64'({1'b1, 16'h7777}));

    // R1, R8, R6, R9: fill with a mix, then release all ports at once
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); idle_inputs();
      put((k == 2) ? 2'd1 : ((k == 3 || k == 4) ? 2'd2 : 2'd0), 8'(8'h21 + k),
          1'b1, 4'd0, 16'h0, 1'b1, 4'd0, 16'h0);
      #2;
      chk(in_ready === 1'b1, $sformatf("R1 ready before insert %0d", k), 64'(in_ready), 64'd1);
    end
    @(negedge clk); idle_inputs();
    put(2'd0, 8'h2F, 1'b1, 4'd0, 16'h0, 1'b1, 4'd0, 16'h0);
    #2;
    chk(in_ready === 1'b0, "R1 stall when full", 64'(in_ready), 64'd0);
    @(negedge clk); idle_inputs(); du_ready = '1;
    #2;
    chk(du_valid === 5'b01111, "R8 cap of four", 64'(du_valid), 64'b01111);
    chk(du_op[0] === 8'h21 && du_op[1] === 8'h22 && du_op[2] === 8'h23 && du_op[3] === 8'h24,
        "R6 oldest first cycle 1", 64'({du_op[3], du_op[2], du_op[1], du_op[0]}), 64'h24232221);
    @(negedge clk); du_ready = '1;
    #2;
    chk(du_valid === 5'b01011, "R8 second cycle mask", 64'(du_valid), 64'b01011);
    chk(du_op[0] === 8'h26 && du_op[1] === 8'h27 && du_op[3] === 8'h25,
        "R6 oldest first cycle 2", 64'({du_op[3], du_op[1], du_op[0]}), 64'h252726);
    @(negedge clk); du_ready = '1;
    #2;
    chk(du_valid === 5'b00001 && du_op[0] === 8'h28, "R9 last entry",
        64'({du_valid, du_op[0]}), 64'({5'b00001, 8'h28}));
    @(negedge clk); du_ready = '1;
    #2;
    chk(du_valid === 5'b00000, "R9 R1 nothing left, dropped insert absent",
        64'(du_valid), 64'd0);

    // R10: flush
    @(negedge clk); idle_inputs();
    put(2'd0, 8'h31, 1'b1, 4'd0, 16'h0, 1'b1, 4'd0, 16'h0);
    @(negedge clk); idle_inputs();
    put(2'd0, 8'h32, 1'b1, 4'd0, 16'h0, 1'b1, 4'd0, 16'h0);
    @(negedge clk); idle_inputs();
    put(2'd0, 8'h33, 1'b1, 4'd0, 16'h0, 1'b1, 4'd0, 16'h0);
    flush = 1'b1; du_ready = '1;
    #2;
    chk(du_valid === '0, "R10 no dispatch during flush", 64'(du_valid), 64'd0);
    chk(in_ready === 1'b0, "R10 stall during flush", 64'(in_ready), 64'd0);
    @(negedge clk); idle_inputs(); du_ready = '1;
    #2;
    chk(du_valid === '0, "R10 empty after flush", 64'(du_valid), 64'd0);
    chk(in_ready === 1'b1, "R10 ready after flush", 64'(in_ready), 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule